// File: doc/BRIEF.md
# Infrared Carrier Transmit Modulator

This block sits between a UART and the two pins of a serial optical port. On the transmit side it either passes the serial data straight to the pin, or it gates that data with a carrier of about 38 kHz so that an infrared emitter can be pulsed. It can also invert the pin polarity or release the pin entirely. On the receive side it brings the raw pin level into the clock domain and can invert it.

The carrier comes from a free-running divider. `CARRIER_DIV` sets how many system clocks make one carrier period; for a real carrier it is the clock rate divided by 38 kHz and must be a multiple of 16. Each period begins with its high phase and ends with its low phase. The length of the low phase is selected by a two-bit duty code. A new duty code, and the start or end of a carrier burst, are only applied at a period boundary, so the pin never shows a truncated pulse. Modulation is forced off whenever the brownout flag is high.

Top module: `ir_tx_modulator`

## Requirements
- R1: The low time in each carrier period is `CARRIER_DIV >> (duty_sel + 1)` clocks. The code `duty_sel` 00 gives 50 %, 01 gives 25 %, 10 gives 12.5 % and 11 gives 6.25 %.
- R2: A carrier period is exactly `CARRIER_DIV` clocks long and has one low run. The high phase comes first and the low phase ends the period.
- R3: A change of `duty_sel` takes effect only at the next period boundary. The current period finishes with its old low time.
- R4: With modulation active, a space (`ser_tx` = 0) sends carrier periods and a mark (`ser_tx` = 1) holds the line high before inversion. Bursts start and stop only at period boundaries, so every low run on the pin has the full selected length.
- R5: While `brownout` = 1, modulation is suppressed even if `mod_enable` = 1. `tx_line` then equals the `ser_tx` and `tx_invert` values sampled one clock earlier, XORed together.
- R6: With `mod_enable` = 0 and `tx_disable` = 0, `tx_line` equals `ser_tx` XOR `tx_invert` as sampled one clock earlier.
- R7: `tx_drive_en` equals the inverse of `tx_disable` one clock earlier. While the transmitter is disabled, `tx_line` holds the idle level, 1 XOR `tx_invert`.
- R8: `tx_invert` = 1 inverts the transmit level in every mode, including the modulated carrier and the disabled idle level.
- R9: `ser_rx` equals `rx_line` delayed by two clocks through a two-stage synchroniser, XORed with the current `rx_invert`.
- R10: While `rst_n` is low, `tx_drive_en` = 0 and `tx_line` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| tx_disable | input | 1 | 1 releases the transmit pin |
| mod_enable | input | 1 | 1 enables carrier modulation |
| duty_sel | input | 2 | Carrier low-time code (see R1) |
| tx_invert | input | 1 | Inverts the transmit pin polarity |
| rx_invert | input | 1 | Inverts the receive data polarity |
| brownout | input | 1 | Brownout mode; forces modulation off |
| ser_tx | input | 1 | Serial transmit data from the UART |
| rx_line | input | 1 | Raw receive pin level |
| tx_line | output | 1 | Registered transmit pin level |
| tx_drive_en | output | 1 | Output enable for the transmit pin |
| ser_rx | output | 1 | Synchronised and optionally inverted receive data |

## Verification
A divider phase that slips shows up at the pin within one carrier period. The spacing between falling edges then differs from `CARRIER_DIV`, or a low run has the wrong length. A duty register or burst gate loaded outside a boundary shows up as a truncated low run in the period where the change happened. A wrong override or inversion path is visible on the clock right after the stimulus, because the pin and the enable are each a single register away from the inputs. A synchroniser of the wrong depth shifts `ser_rx` by one or more clocks against the two-clock expectation.

// File: rtl/ir_mod_pkg.sv
package ir_mod_pkg;

  // Carrier low-time codes.
  typedef enum logic [1:0] {
    DUTY_HALF      = 2'b00,
    DUTY_QUARTER   = 2'b01,
    DUTY_EIGHTH    = 2'b10,
    DUTY_SIXTEENTH = 2'b11
  } duty_code_e;

  // Line level of a UART mark, before any inversion.
  localparam logic LINE_IDLE = 1'b1;

endpackage

// File: rtl/ir_carrier_gen.sv
// Free-running carrier divider. Each period starts with its high phase and
// ends with its low phase. The duty code is loaded only on the final cycle
// of a period.
module ir_carrier_gen
  import ir_mod_pkg::*;
#(
  parameter int unsigned DIV = 32,
  parameter int unsigned CW  = $clog2(DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    duty_req,
  output logic          carrier,
  output logic          wrap,
  output logic [CW-1:0] phase,
  output logic [1:0]    duty_act
);

  localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
  localparam logic [CW:0]   FULL  = (CW+1)'(DIV);

  logic [CW-1:0] phase_q, phase_d;
  duty_code_e    duty_q,  duty_d;
  logic [CW:0]   low_len, high_len;

  // next state
  always_comb begin
    wrap    = (phase_q == LAST);
    phase_d = wrap ? '0 : phase_q + 1'b1;
    duty_d  = duty_code_e'(duty_req);
  end

  // carrier shape from the active duty code
  always_comb begin
    low_len  = FULL >> ({1'b0, duty_q} + 3'd1);
    high_len = FULL - low_len;
    carrier  = ({1'b0, phase_q} < high_len);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      duty_q  <= DUTY_HALF;
    end else begin
      phase_q <= phase_d;
      if (wrap) begin
        duty_q <= duty_d;
      end
    end
  end

  assign phase    = phase_q;
  assign duty_act = duty_q;

endmodule

// File: rtl/ir_tx_shaper.sv
// Transmit path: burst gate, brownout override, disable and polarity.
module ir_tx_shaper
  import ir_mod_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic carrier,
  input  logic wrap,
  input  logic ser_tx,
  input  logic mod_enable,
  input  logic brownout,
  input  logic tx_disable,
  input  logic tx_invert,
  output logic tx_line,
  output logic tx_drive_en,
  output logic burst
);

  logic mod_live;
  logic burst_q, burst_d;
  logic level;
  logic line_q, line_d;
  logic oe_q, oe_d;

  // next state
  always_comb begin
    mod_live = mod_enable & ~brownout;

    // A burst is opened or closed only at a period boundary. It is dropped
    // at once when modulation goes away.
    if (!mod_live) begin
      burst_d = 1'b0;
    end else if (wrap) begin
      burst_d = ~ser_tx;
    end else begin
      burst_d = burst_q;
    end

    if (mod_live) begin
      level = burst_q ? carrier : LINE_IDLE;
    end else begin
      level = ser_tx;
    end

    line_d = (tx_disable ? LINE_IDLE : level) ^ tx_invert;
    oe_d   = ~tx_disable;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      line_q  <= LINE_IDLE;
      oe_q    <= 1'b0;
    end else begin
      burst_q <= burst_d;
      line_q  <= line_d;
      oe_q    <= oe_d;
    end
  end

  assign tx_line     = line_q;
  assign tx_drive_en = oe_q;
  assign burst       = burst_q;

endmodule

// File: rtl/ir_rx_sync.sv
// Synchroniser chain for the raw receive pin.
module ir_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic src;
    if (g == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = chain_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q[g] <= 1'b1;
      end else begin
        chain_q[g] <= src;
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/ir_tx_modulator.sv
module ir_tx_modulator
  import ir_mod_pkg::*;
#(
  parameter int unsigned CARRIER_DIV    = 32,
  parameter int unsigned RX_SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_disable,
  input  logic       mod_enable,
  input  logic [1:0] duty_sel,
  input  logic       tx_invert,
  input  logic       rx_invert,
  input  logic       brownout,
  input  logic       ser_tx,
  input  logic       rx_line,
  output logic       tx_line,
  output logic       tx_drive_en,
  output logic       ser_rx
);

  localparam int unsigned CNT_W = $clog2(CARRIER_DIV);

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic             car_level;
  logic             car_wrap;
  logic [CNT_W-1:0] car_phase;
  logic [1:0]       car_duty;
  logic             tx_burst;
  logic             rx_synced;

  ir_carrier_gen #(
    .DIV (CARRIER_DIV),
    .CW  (CNT_W)
  ) u_carrier (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .duty_req (duty_sel),
    .carrier  (car_level),
    .wrap     (car_wrap),
    .phase    (car_phase),
    .duty_act (car_duty)
  );

  ir_tx_shaper u_shaper (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .carrier     (car_level),
    .wrap        (car_wrap),
    .ser_tx      (ser_tx),
    .mod_enable  (mod_enable),
    .brownout    (brownout),
    .tx_disable  (tx_disable),
    .tx_invert   (tx_invert),
    .tx_line     (tx_line),
    .tx_drive_en (tx_drive_en),
    .burst       (tx_burst)
  );

  ir_rx_sync #(
    .STAGES (RX_SYNC_STAGES)
  ) u_rx_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (rx_line),
    .q     (rx_synced)
  );

  assign ser_rx = rx_synced ^ rx_invert;

endmodule

// File: rtl/ir_tx_modulator_chk.sv
module ir_tx_modulator_chk #(
  parameter int unsigned DIV = 32,
  parameter int unsigned CW  = $clog2(DIV)
) (
  input logic          clk,
  input logic          rst_s,
  input logic          tx_disable,
  input logic          tx_invert,
  input logic          ser_tx,
  input logic          mod_enable,
  input logic          brownout,
  input logic          rx_line,
  input logic          rx_invert,
  input logic          tx_line,
  input logic          tx_drive_en,
  input logic          ser_rx,
  input logic [CW-1:0] phase,
  input logic [1:0]    duty,
  input logic          burst
);

  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  // cycles since the internal reset was released, saturating
  logic [2:0] up_q;
  logic       live;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      up_q <= '0;
    end else if (up_q != 3'd7) begin
      up_q <= up_q + 3'd1;
    end
  end
  assign live = (up_q >= 3'd4);

  assert_oe_follows_disable_R7: assert property (@(posedge clk) disable iff (!rst_s)
    live |-> (tx_drive_en == !$past(tx_disable)));

  assert_disabled_idle_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (live && $past(tx_disable)) |-> (tx_line == !$past(tx_invert)));

  assert_brownout_passthru_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (live && $past(brownout) && !$past(tx_disable))
      |-> (tx_line == ($past(ser_tx) ^ $past(tx_invert))));

  assert_plain_passthru_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (live && !$past(mod_enable) && !$past(tx_disable))
      |-> (tx_line == ($past(ser_tx) ^ $past(tx_invert))));

  assert_rx_two_stage_R9: assert property (@(posedge clk) disable iff (!rst_s)
    live |-> (ser_rx == ($past(rx_line, 2) ^ rx_invert)));

  assert_period_wrap_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (live && phase == LAST) |=> (phase == '0));

  assert_period_step_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (live && phase != LAST) |=> (phase == $past(phase) + 1'b1));

  assert_duty_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (live && $past(phase) != LAST) |-> $stable(duty));

  assert_burst_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (live && $past(phase) != LAST) |-> !$rose(burst));

endmodule

bind ir_tx_modulator ir_tx_modulator_chk #(
  .DIV (CARRIER_DIV),
  .CW  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_s       (rst_sync_n),
  .tx_disable  (tx_disable),
  .tx_invert   (tx_invert),
  .ser_tx      (ser_tx),
  .mod_enable  (mod_enable),
  .brownout    (brownout),
  .rx_line     (rx_line),
  .rx_invert   (rx_invert),
  .tx_line     (tx_line),
  .tx_drive_en (tx_drive_en),
  .ser_rx      (ser_rx),
  .phase       (car_phase),
  .duty        (car_duty),
  .burst       (tx_burst)
);

// File: tb/ir_tx_modulator_bench.sv
module ir_tx_modulator_bench;

  localparam int DIV = 32;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_disable, mod_enable, tx_invert, rx_invert, brownout;
  logic [1:0] duty_sel;
  logic       ser_tx, rx_line;
  logic       tx_line, tx_drive_en, ser_rx;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  ir_tx_modulator #(.CARRIER_DIV(DIV), .RX_SYNC_STAGES(2)) u_ir_tx_modulator (
    .clk(clk), .rst_n(rst_n), .tx_disable(tx_disable), .mod_enable(mod_enable),
    .duty_sel(duty_sel), .tx_invert(tx_invert), .rx_invert(rx_invert),
    .brownout(brownout), .ser_tx(ser_tx), .rx_line(rx_line),
    .tx_line(tx_line), .tx_drive_en(tx_drive_en), .ser_rx(ser_rx)
  );

  function automatic int exp_low(int sel);
    return DIV >> (sel + 1);
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Samples n cycles and checks every complete low run against a or b.
  task automatic watch_runs(int n, int a, int b, bit rand_data, string tag,
                            output int first_run, output int last_run, output int nruns);
    int run = 0;
    bit seen_high = 0;
    first_run = -1; last_run = -1; nruns = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_line == 1'b0) begin
        run++;
      end else begin
        if (run > 0 && seen_high) begin
          chk(run == a || run == b, tag, run, a);
          if (nruns == 0) first_run = run;
          last_run = run;
          nruns++;
        end
        run = 0;
        seen_high = 1;
      end
      if (rand_data && ($urandom % 24) == 0) ser_tx = ~ser_tx;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int lows, falls, maxrun, run, fr, lr, nr, prev, last_d, h1, h2, sel, highs;
    void'($urandom(32'h1D3A5));
    rst_n = 0; tx_disable = 1; mod_enable = 0; duty_sel = 0; tx_invert = 0;
    rx_invert = 0; brownout = 0; ser_tx = 1; rx_line = 1;
    cyc(3);
    // R10 reset state
    chk(tx_drive_en == 0, "R10 oe in reset", tx_drive_en, 0);
    chk(tx_line == 1, "R10 line in reset", tx_line, 1);
    rst_n = 1;
    cyc(10);

    // R7 / R8 disabled idle level and enable
    chk(tx_drive_en == 0, "R7 oe disabled", tx_drive_en, 0);
    chk(tx_line == 1, "R7 idle level", tx_line, 1);
    tx_invert = 1;
    cyc(1);
    chk(tx_line == 0, "R8 inverted idle", tx_line, 0);
    tx_invert = 0; tx_disable = 0;
    cyc(1);
    chk(tx_drive_en == 1, "R7 oe enabled", tx_drive_en, 1);

    // R6 / R8 unmodulated pass-through
    for (int k = 0; k < 2; k++) begin
      tx_invert = k[0];
      last_d = $urandom % 2; ser_tx = last_d[0];
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        chk(tx_line == (last_d[0] ^ tx_invert), k ? "R8 inverted pass" : "R6 pass-through",
            tx_line, last_d ^ k);
        last_d = $urandom % 2; ser_tx = last_d[0];
      end
    end
    tx_invert = 0;

    // R1 / R2 duty and period, constant space
    mod_enable = 1; ser_tx = 0;
    for (int s = 0; s < 4; s++) begin
      duty_sel = s[1:0];
      cyc(3 * DIV);
      lows = 0; falls = 0; maxrun = 0; run = 0; prev = tx_line;
      for (int i = 0; i < 4 * DIV; i++) begin
        @(negedge clk);
        if (tx_line == 0) begin
          lows++; run++;
          if (run > maxrun) maxrun = run;
          if (prev == 1) falls++;
        end else begin
          run = 0;
        end
        prev = tx_line;
      end
      chk(lows == 4 * exp_low(s), "R1 low clocks per 4 periods", lows, 4 * exp_low(s));
      chk(maxrun == exp_low(s), "R1 low run length", maxrun, exp_low(s));
      chk(falls == 4, "R2 one low run per period", falls, 4);
    end

    // R8 inversion of the carrier
    tx_invert = 1; duty_sel = 2'b11;
    cyc(3 * DIV);
    highs = 0;
    for (int i = 0; i < 4 * DIV; i++) begin
      @(negedge clk);
      if (tx_line == 1) highs++;
    end
    chk(highs == 4 * exp_low(3), "R8 inverted carrier", highs, 4 * exp_low(3));
    tx_invert = 0;

    // R3 duty change in mid-period
    duty_sel = 2'b00;
    cyc(3 * DIV);
    while (tx_line != 0) @(negedge clk);
    cyc(20);
    duty_sel = 2'b11;
    watch_runs(4 * DIV, exp_low(0), exp_low(3), 0, "R3 only whole runs", fr, lr, nr);
    chk(fr == exp_low(0), "R3 current period keeps old duty", fr, exp_low(0));
    chk(lr == exp_low(3), "R3 new duty after boundary", lr, exp_low(3));
    chk(nr >= 3, "R3 run count", nr, 3);

    // R4 random mark/space, full runs only
    for (int seg = 0; seg < 6; seg++) begin
      sel = $urandom % 4;
      duty_sel = sel[1:0];
      ser_tx = 1;
      cyc(2 * DIV);
      watch_runs(12 * DIV, exp_low(sel), exp_low(sel), 1, "R4 burst runs whole", fr, lr, nr);
    end
    // R4 mark holds idle
    ser_tx = 1;
    cyc(2 * DIV + 2);
    lows = 0;
    for (int i = 0; i < 2 * DIV; i++) begin
      @(negedge clk);
      if (tx_line == 0) lows++;
    end
    chk(lows == 0, "R4 mark idle", lows, 0);
    // R4 space sends carrier
    ser_tx = 0; duty_sel = 2'b01;
    cyc(3 * DIV);
    lows = 0;
    for (int i = 0; i < 2 * DIV; i++) begin
      @(negedge clk);
      if (tx_line == 0) lows++;
    end
    chk(lows == 2 * exp_low(1), "R4 space bursts", lows, 2 * exp_low(1));

    // R5 brownout overrides modulation
    brownout = 1;
    last_d = $urandom % 2; ser_tx = last_d[0];
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      chk(tx_line == last_d[0], "R5 brownout pass-through", tx_line, last_d);
      last_d = $urandom % 2; ser_tx = last_d[0];
    end
    brownout = 0; ser_tx = 0;
    cyc(3 * DIV);

    // R7 disable during a burst
    tx_disable = 1; tx_invert = $urandom % 2;
    cyc(1);
    for (int i = 0; i < 2 * DIV; i++) begin
      chk(tx_line == !tx_invert, "R7 disabled holds idle", tx_line, !tx_invert);
      chk(tx_drive_en == 0, "R7 oe low", tx_drive_en, 0);
      @(negedge clk);
    end
    tx_disable = 0; tx_invert = 0; mod_enable = 0;

    // R9 receive path
    for (int k = 0; k < 2; k++) begin
      rx_invert = k[0];
      h1 = rx_line; h2 = rx_line;
      cyc(3);
      h1 = rx_line; h2 = rx_line;
      for (int i = 0; i < 150; i++) begin
        @(negedge clk);
        chk(ser_rx == (h2[0] ^ rx_invert), "R9 rx sync", ser_rx, h2 ^ k);
        h2 = h1;
        h1 = $urandom % 2;
        rx_line = h1[0];
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule